// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

The block watches the instruction fetch address stream and the data access address stream of a processor core. It raises a single debug request pulse when an address matches one of the programmed breakpoints. Each pulse carries a cause code. Two instruction breakpoint registers and two data breakpoint registers are loaded through a write-only register port. A data control register arms each data comparator for stores, loads or either kind of access. One bit of the same register turns the second data register into a don't-care mask on the first, so the pair matches an address window instead of two single addresses.

Besides address matches, the block merges four more request sources into the same output, each with its own cause code: a software breakpoint strobe, an external debug request, an exception vector trap and a trace-storage-full indication. If several requests arrive in the same cycle, only the highest-priority one is reported. After a request pulse the block stays in a debug state and drops all further requests until the debug handler signals exit.

Top module: `bkpt_unit`

## Requirements
- R1: After reset `hit_o` is 0, `cause_o` is 0, and every comparator is disabled, so a fetch or data access to any address, including address 0, raises no request.
- R2: An instruction breakpoint register (offset 0 or 1) with bit 0 set matches a fetch whose address bits [31:2] equal register bits [31:2]. Fetch bits [1:0] are ignored. `hit_o` pulses with `cause_o` = 1 in the cycle after the fetch strobe.
- R3: An instruction breakpoint register with bit 0 clear never matches, whatever the fetch address.
- R4: Data control bits [1:0] arm data comparator 0 and bits [3:2] arm comparator 1. The codes are 00 = off, 01 = stores only, 10 = any access and 11 = loads only, with `dacc_st_i` = 1 marking a store. A data match reports `cause_o` = 2.
- R5: With data control bit 4 clear, each data comparator matches only the exact full address held in its register (offset 2 or 3).
- R6: With data control bit 4 set, comparator 0 matches when ((address XOR reg2) AND NOT reg3) is zero, using the access type from bits [1:0]. Comparator 1 then never matches on its own.
- R7: When causes coincide, the cause reported follows the priority external (4) > instruction (1) > data (2) > vector trap (5) > trace full (6) > software (3).
- R8: `hit_o` is high for exactly one cycle. After it, every request source is ignored until `dbg_exit_i` has been high for one cycle. From the cycle after that, requests are accepted again.
- R9: A register write takes effect in the cycle after it is presented. A fetch or access in the same cycle as the write is compared against the old value.
- R10: The register offsets are 0 and 1 for instruction breakpoints, 2 and 3 for data breakpoints, and 4 for data control. Writes to offsets 5 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| fetch_vld_i | input | 1 | Instruction fetch strobe |
| fetch_addr_i | input | 32 | Instruction fetch address |
| dacc_vld_i | input | 1 | Data access strobe |
| dacc_addr_i | input | 32 | Data access address |
| dacc_st_i | input | 1 | 1 = store, 0 = load |
| swbp_i | input | 1 | Software breakpoint request |
| ext_dbg_i | input | 1 | External debug request |
| vec_trap_i | input | 1 | Exception vector trap request |
| trace_full_i | input | 1 | Trace storage full request |
| dbg_exit_i | input | 1 | Debug handler exit, clears the debug state |
| hit_o | output | 1 | Debug request pulse |
| cause_o | output | 3 | Cause code, valid with `hit_o`, else 0 |

## Verification
The bench uses the default 32-bit address width and 3-bit register offset, so every offset is reached, including the three unused ones. Addresses that differ only in the top bit, only in the two byte-select bits, or only inside and outside an 8-bit mask window are all representable. This lets the bench separate a word-aligned instruction compare from an exact data compare and from a masked range compare. The bench also drives all six request sources in one cycle and then removes them one by one, which walks the whole priority chain.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int N_IBP  = 2;
  localparam int DCTL_W = 5;
  localparam int CAUSE_W = 3;

  localparam logic [2:0] OFF_IBP0 = 3'd0;
  localparam logic [2:0] OFF_DBP0 = 3'd2;
  localparam logic [2:0] OFF_DBP1 = 3'd3;
  localparam logic [2:0] OFF_DCTL = 3'd4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_IBP   = 3'd1,
    CAUSE_DBP   = 3'd2,
    CAUSE_SWBP  = 3'd3,
    CAUSE_EXT   = 3'd4,
    CAUSE_VEC   = 3'd5,
    CAUSE_TRACE = 3'd6
  } cause_e;

  typedef enum logic [1:0] {
    DMODE_OFF   = 2'b00,
    DMODE_STORE = 2'b01,
    DMODE_ANY   = 2'b10,
    DMODE_LOAD  = 2'b11
  } dmode_e;

  typedef struct packed {
    logic   mask_en;
    dmode_e mode1;
    dmode_e mode0;
  } dctl_t;
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [REG_AW-1:0]                addr_i,
  input  logic [ADDR_W-1:0]                wdata_i,
  output logic [N_IBP-1:0][ADDR_W-3:0]     ibp_addr_o,
  output logic [N_IBP-1:0]                 ibp_en_o,
  output logic [ADDR_W-1:0]                dbp0_o,
  output logic [ADDR_W-1:0]                dbp1_o,
  output dctl_t                            dctl_o
);
  for (genvar i = 0; i < N_IBP; i++) begin : g_ibp
    logic sel;
    assign sel = we_i && (addr_i == REG_AW'(OFF_IBP0 + 3'(i)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ibp_addr_o[i] <= '0;
        ibp_en_o[i]   <= 1'b0;
      end else if (sel) begin
        ibp_addr_o[i] <= wdata_i[ADDR_W-1:2];
        ibp_en_o[i]   <= wdata_i[0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbp0_o <= '0;
      dbp1_o <= '0;
      dctl_o <= '0;
    end else if (we_i) begin
      if (addr_i == REG_AW'(OFF_DBP0)) dbp0_o <= wdata_i;
      if (addr_i == REG_AW'(OFF_DBP1)) dbp1_o <= wdata_i;
      if (addr_i == REG_AW'(OFF_DCTL)) dctl_o <= dctl_t'(wdata_i[DCTL_W-1:0]);
    end
  end

  assert_dctl_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_AW'(OFF_DCTL)) |=> (dctl_o == $past(wdata_i[DCTL_W-1:0])));
  assert_dbp0_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == REG_AW'(OFF_DBP0)) |=> $stable(dbp0_o));
endmodule

// File: rtl/bkpt_icmp.sv
module bkpt_icmp
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         fetch_vld_i,
  input  logic [ADDR_W-3:0]            fetch_word_i,
  input  logic [N_IBP-1:0][ADDR_W-3:0] ibp_addr_i,
  input  logic [N_IBP-1:0]             ibp_en_i,
  output logic                         match_o
);
  logic [N_IBP-1:0] hit;

  for (genvar i = 0; i < N_IBP; i++) begin : g_cmp
    assign hit[i] = fetch_vld_i && ibp_en_i[i] && (fetch_word_i == ibp_addr_i[i]);

    assert_ibp_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ibp_en_i[i] |-> !hit[i]);
  end

  assign match_o = |hit;

  assert_no_fetch_no_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_vld_i |-> !match_o);
endmodule

// File: rtl/bkpt_dcmp.sv
module bkpt_dcmp
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              st_i,
  input  logic [ADDR_W-1:0] dbp0_i,
  input  logic [ADDR_W-1:0] dbp1_i,
  input  dctl_t             dctl_i,
  output logic              match_o
);
  function automatic logic kind_ok(dmode_e m, logic st);
    case (m)
      DMODE_STORE: kind_ok = st;
      DMODE_ANY:   kind_ok = 1'b1;
      DMODE_LOAD:  kind_ok = !st;
      default:     kind_ok = 1'b0;
    endcase
  endfunction

  logic [ADDR_W-1:0] care0;
  logic              m0, m1;

  // mask mode: ones in dbp1 are don't-care bits for comparator 0
  assign care0   = dctl_i.mask_en ? ~dbp1_i : '1;
  assign m0      = vld_i && kind_ok(dctl_i.mode0, st_i) && (((addr_i ^ dbp0_i) & care0) == '0);
  assign m1      = vld_i && !dctl_i.mask_en && kind_ok(dctl_i.mode1, st_i) && (addr_i == dbp1_i);
  assign match_o = m0 || m1;

  assert_both_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dctl_i.mode0 == DMODE_OFF && dctl_i.mode1 == DMODE_OFF) |-> !match_o);
  assert_mask_silences_cmp1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dctl_i.mask_en && dctl_i.mode0 == DMODE_OFF) |-> !match_o);
  assert_store_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !st_i && dctl_i.mode0 == DMODE_STORE && dctl_i.mode1 == DMODE_STORE) |-> !match_o);
endmodule

// File: rtl/bkpt_arb.sv
module bkpt_arb
  import bkpt_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ext_i,
  input  logic   ibp_i,
  input  logic   dbp_i,
  input  logic   vec_i,
  input  logic   trace_i,
  input  logic   sw_i,
  input  logic   exit_i,
  output logic   hit_o,
  output cause_e cause_o
);
  cause_e cause_d;
  logic   any_d, hit_d, in_dbg_q;

  always_comb begin
    cause_d = CAUSE_NONE;
    if      (ext_i)   cause_d = CAUSE_EXT;
    else if (ibp_i)   cause_d = CAUSE_IBP;
    else if (dbp_i)   cause_d = CAUSE_DBP;
    else if (vec_i)   cause_d = CAUSE_VEC;
    else if (trace_i) cause_d = CAUSE_TRACE;
    else if (sw_i)    cause_d = CAUSE_SWBP;
  end

  assign any_d = ext_i | ibp_i | dbp_i | vec_i | trace_i | sw_i;
  assign hit_d = any_d && !in_dbg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o    <= 1'b0;
      cause_o  <= CAUSE_NONE;
      in_dbg_q <= 1'b0;
    end else begin
      hit_o   <= hit_d;
      cause_o <= hit_d ? cause_d : CAUSE_NONE;
      if (hit_d)       in_dbg_q <= 1'b1;
      else if (exit_i) in_dbg_q <= 1'b0;
    end
  end

  assert_hit_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);
  assert_blocked_in_dbg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_dbg_q |=> !hit_o);
  assert_ext_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_i && !in_dbg_q) |=> (hit_o && cause_o == CAUSE_EXT));
  assert_cause_with_hit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o == (cause_o != CAUSE_NONE)));
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [ADDR_W-1:0]   reg_wdata_i,
  input  logic                fetch_vld_i,
  input  logic [ADDR_W-1:0]   fetch_addr_i,
  input  logic                dacc_vld_i,
  input  logic [ADDR_W-1:0]   dacc_addr_i,
  input  logic                dacc_st_i,
  input  logic                swbp_i,
  input  logic                ext_dbg_i,
  input  logic                vec_trap_i,
  input  logic                trace_full_i,
  input  logic                dbg_exit_i,
  output logic                hit_o,
  output logic [CAUSE_W-1:0]  cause_o
);
  logic [N_IBP-1:0][ADDR_W-3:0] ibp_addr;
  logic [N_IBP-1:0]             ibp_en;
  logic [ADDR_W-1:0]            dbp0, dbp1;
  dctl_t                        dctl;
  logic                         imatch, dmatch;
  cause_e                       cause;

  bkpt_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .ibp_addr_o(ibp_addr), .ibp_en_o(ibp_en),
    .dbp0_o(dbp0), .dbp1_o(dbp1), .dctl_o(dctl)
  );

  bkpt_icmp #(.ADDR_W(ADDR_W)) u_icmp (
    .clk_i, .rst_ni,
    .fetch_vld_i, .fetch_word_i(fetch_addr_i[ADDR_W-1:2]),
    .ibp_addr_i(ibp_addr), .ibp_en_i(ibp_en),
    .match_o(imatch)
  );

  bkpt_dcmp #(.ADDR_W(ADDR_W)) u_dcmp (
    .clk_i, .rst_ni,
    .vld_i(dacc_vld_i), .addr_i(dacc_addr_i), .st_i(dacc_st_i),
    .dbp0_i(dbp0), .dbp1_i(dbp1), .dctl_i(dctl),
    .match_o(dmatch)
  );

  bkpt_arb u_arb (
    .clk_i, .rst_ni,
    .ext_i(ext_dbg_i), .ibp_i(imatch), .dbp_i(dmatch),
    .vec_i(vec_trap_i), .trace_i(trace_full_i), .sw_i(swbp_i),
    .exit_i(dbg_exit_i),
    .hit_o, .cause_o(cause)
  );

  assign cause_o = cause;

  assert_fetch_low_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_vld_i && imatch) |-> (fetch_addr_i[1:0] == fetch_addr_i[1:0]) && ibp_en != '0);
endmodule

// File: tb/sim_bkpt_unit.sv
`timescale 1ns/1ps
module sim_bkpt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        fetch_vld = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        dacc_vld = 1'b0;
  logic [31:0] dacc_addr = '0;
  logic        dacc_st = 1'b0;
  logic        swbp = 1'b0, ext_dbg = 1'b0, vec_trap = 1'b0, trace_full = 1'b0;
  logic        dbg_exit = 1'b0;
  logic        hit;
  logic [2:0]  cause;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bkpt_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .fetch_vld_i(fetch_vld), .fetch_addr_i(fetch_addr),
    .dacc_vld_i(dacc_vld), .dacc_addr_i(dacc_addr), .dacc_st_i(dacc_st),
    .swbp_i(swbp), .ext_dbg_i(ext_dbg), .vec_trap_i(vec_trap), .trace_full_i(trace_full),
    .dbg_exit_i(dbg_exit),
    .hit_o(hit), .cause_o(cause)
  );

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic exit_dbg;
    @(negedge clk); dbg_exit = 1'b1;
    @(negedge clk); dbg_exit = 1'b0;
  endtask

  // misc = {ext, vec, trace, sw}
  task automatic fire(input logic fv, input logic [31:0] fa,
                      input logic dv, input logic [31:0] da, input logic st,
                      input logic [3:0] misc,
                      output logic h, output logic [2:0] c);
    @(negedge clk);
    fetch_vld = fv; fetch_addr = fa;
    dacc_vld = dv; dacc_addr = da; dacc_st = st;
    {ext_dbg, vec_trap, trace_full, swbp} = misc;
    @(posedge clk); #1;
    h = hit; c = cause;
    @(negedge clk);
    fetch_vld = 1'b0; dacc_vld = 1'b0; {ext_dbg, vec_trap, trace_full, swbp} = '0;
  endtask

  task automatic expect_req(input string req, input logic h, input logic [2:0] c,
                            input logic eh, input logic [2:0] ec);
    n_chk++;
    if (h !== eh || c !== ec) begin
      n_bad++;
      $display("FAIL %s: actual hit=%0b cause=%0d expected hit=%0b cause=%0d", req, h, c, eh, ec);
    end
    if (h === 1'b1) exit_dbg();
  endtask

  task automatic t_reset;
    logic h; logic [2:0] c;
    @(posedge clk); #1;
    expect_req("R1 reset outputs", hit, cause, 1'b0, 3'd0);
    fire(1'b1, 32'h0, 1'b0, 32'h0, 1'b0, 4'b0, h, c);
    expect_req("R1 fetch addr 0 after reset", h, c, 1'b0, 3'd0);
    fire(1'b0, 32'h0, 1'b1, 32'h0, 1'b1, 4'b0, h, c);
    expect_req("R1 store addr 0 after reset", h, c, 1'b0, 3'd0);
    fire(1'b0, 32'h0, 1'b1, 32'h0, 1'b0, 4'b0, h, c);
    expect_req("R1 load addr 0 after reset", h, c, 1'b0, 3'd0);
  endtask

  task automatic t_ibp;
    logic h; logic [2:0] c;
    wr(3'd0, 32'h4000_0101);
    wr(3'd1, 32'h8000_0001);
    fire(1'b1, 32'h4000_0100, 1'b0, 0, 1'b0, 4'b0, h, c);
    expect_req("R2 ibp0 exact word", h, c, 1'b1, 3'd1);
    fire(1'b1, 32'h4000_0103, 1'b0, 0, 1'b0, 4'b0, h, c);
    expect_req("R2 ibp0 low bits ignored", h, c, 1'b1, 3'd1);
    fire(1'b1, 32'h4000_0104, 1'b0, 0, 1'b0, 4'b0, h, c);
    expect_req("R2 ibp0 next word no match", h, c, 1'b0, 3'd0);
    fire(1'b1, 32'h8000_0000, 1'b0, 0, 1'b0, 4'b0, h, c);
    expect_req("R2 ibp1 top bit", h, c, 1'b1, 3'd1);
    fire(1'b1, 32'h0000_0000, 1'b0, 0, 1'b0, 4'b0, h, c);
    expect_req("R2 ibp1 top bit differs", h, c, 1'b0, 3'd0);
  endtask

  task automatic t_ibp_off;
    logic h; logic [2:0] c;
    wr(3'd0, 32'h4000_0100);
    wr(3'd1, 32'h8000_0000);
    fire(1'b1, 32'h4000_0100, 1'b0, 0, 1'b0, 4'b0, h, c);
    expect_req("R3 ibp0 disabled", h, c, 1'b0, 3'd0);
    fire(1'b1, 32'h8000_0000, 1'b0, 0, 1'b0, 4'b0, h, c);
    expect_req("R3 ibp1 disabled", h, c, 1'b0, 3'd0);
  endtask

  task automatic t_dmodes;
    logic h; logic [2:0] c;
    wr(3'd2, 32'h1000_0000);
    wr(3'd3, 32'h1000_0040);
    wr(3'd4, 32'h0000_0001);
    fire(1'b0, 0, 1'b1, 32'h1000_0000, 1'b1, 4'b0, h, c);
    expect_req("R4 store-only with store", h, c, 1'b1, 3'd2);
    fire(1'b0, 0, 1'b1, 32'h1000_0000, 1'b0, 4'b0, h, c);
    expect_req("R4 store-only with load", h, c, 1'b0, 3'd0);
    wr(3'd4, 32'h0000_0003);
    fire(1'b0, 0, 1'b1, 32'h1000_0000, 1'b0, 4'b0, h, c);
    expect_req("R4 load-only with load", h, c, 1'b1, 3'd2);
    fire(1'b0, 0, 1'b1, 32'h1000_0000, 1'b1, 4'b0, h, c);
    expect_req("R4 load-only with store", h, c, 1'b0, 3'd0);
    wr(3'd4, 32'h0000_0002);
    fire(1'b0, 0, 1'b1, 32'h1000_0000, 1'b1, 4'b0, h, c);
    expect_req("R4 any with store", h, c, 1'b1, 3'd2);
    fire(1'b0, 0, 1'b1, 32'h1000_0000, 1'b0, 4'b0, h, c);
    expect_req("R4 any with load", h, c, 1'b1, 3'd2);
    fire(1'b0, 0, 1'b1, 32'h1000_0001, 1'b0, 4'b0, h, c);
    expect_req("R5 exact address, byte differs", h, c, 1'b0, 3'd0);
    wr(3'd4, 32'h0000_0004);
    fire(1'b0, 0, 1'b1, 32'h1000_0040, 1'b1, 4'b0, h, c);
    expect_req("R4 cmp1 store-only match", h, c, 1'b1, 3'd2);
    fire(1'b0, 0, 1'b1, 32'h1000_0000, 1'b1, 4'b0, h, c);
    expect_req("R5 cmp0 off, cmp1 other addr", h, c, 1'b0, 3'd0);
    wr(3'd4, 32'h0000_0000);
    fire(1'b0, 0, 1'b1, 32'h1000_0040, 1'b1, 4'b0, h, c);
    expect_req("R4 both off", h, c, 1'b0, 3'd0);
  endtask

  task automatic t_mask;
    logic h; logic [2:0] c;
    wr(3'd2, 32'h2000_0000);
    wr(3'd3, 32'h0000_00FF);
    wr(3'd4, 32'h0000_0012);
    fire(1'b0, 0, 1'b1, 32'h2000_00A4, 1'b0, 4'b0, h, c);
    expect_req("R6 inside mask window", h, c, 1'b1, 3'd2);
    fire(1'b0, 0, 1'b1, 32'h2000_0100, 1'b1, 4'b0, h, c);
    expect_req("R6 outside mask window", h, c, 1'b0, 3'd0);
    wr(3'd4, 32'h0000_0018);
    fire(1'b0, 0, 1'b1, 32'h0000_00FF, 1'b1, 4'b0, h, c);
    expect_req("R6 cmp1 silent in mask mode", h, c, 1'b0, 3'd0);
    wr(3'd4, 32'h0000_0008);
    fire(1'b0, 0, 1'b1, 32'h0000_00FF, 1'b1, 4'b0, h, c);
    expect_req("R6 cmp1 active without mask", h, c, 1'b1, 3'd2);
  endtask

  task automatic t_prio;
    logic h; logic [2:0] c;
    wr(3'd0, 32'h3000_0001);
    wr(3'd2, 32'h3000_1000);
    wr(3'd4, 32'h0000_0002);
    fire(1'b1, 32'h3000_0000, 1'b1, 32'h3000_1000, 1'b0, 4'b1111, h, c);
    expect_req("R7 all sources -> external", h, c, 1'b1, 3'd4);
    fire(1'b1, 32'h3000_0000, 1'b1, 32'h3000_1000, 1'b0, 4'b0111, h, c);
    expect_req("R7 no ext -> instruction", h, c, 1'b1, 3'd1);
    fire(1'b0, 32'h3000_0000, 1'b1, 32'h3000_1000, 1'b0, 4'b0111, h, c);
    expect_req("R7 -> data", h, c, 1'b1, 3'd2);
    fire(1'b0, 0, 1'b0, 0, 1'b0, 4'b0111, h, c);
    expect_req("R7 -> vector trap", h, c, 1'b1, 3'd5);
    fire(1'b0, 0, 1'b0, 0, 1'b0, 4'b0011, h, c);
    expect_req("R7 -> trace full", h, c, 1'b1, 3'd6);
    fire(1'b0, 0, 1'b0, 0, 1'b0, 4'b0001, h, c);
    expect_req("R7 -> software", h, c, 1'b1, 3'd3);
  endtask

  task automatic t_pulse;
    logic h; logic [2:0] c;
    fire(1'b0, 0, 1'b0, 0, 1'b0, 4'b1000, h, c);
    n_chk++;
    if (h !== 1'b1 || c !== 3'd4) begin
      n_bad++; $display("FAIL R8 first request: actual hit=%0b cause=%0d expected hit=1 cause=4", h, c);
    end
    @(posedge clk); #1;
    n_chk++;
    if (hit !== 1'b0) begin
      n_bad++; $display("FAIL R8 pulse width: actual hit=%0b expected hit=0", hit);
    end
    fire(1'b1, 32'h3000_0000, 1'b0, 0, 1'b0, 4'b1001, h, c);
    n_chk++;
    if (h !== 1'b0 || c !== 3'd0) begin
      n_bad++; $display("FAIL R8 ignored in debug: actual hit=%0b cause=%0d expected hit=0 cause=0", h, c);
    end
    exit_dbg();
    fire(1'b0, 0, 1'b0, 0, 1'b0, 4'b0001, h, c);
    expect_req("R8 accepted after exit", h, c, 1'b1, 3'd3);
  endtask

  task automatic t_wr_timing;
    logic h; logic [2:0] c;
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h6000_0001;
    fetch_vld = 1'b1; fetch_addr = 32'h6000_0000;
    @(posedge clk); #1;
    h = hit; c = cause;
    @(negedge clk); reg_we = 1'b0;
    expect_req("R9 same-cycle fetch uses old value", h, c, 1'b0, 3'd0);
    @(posedge clk); #1;
    h = hit; c = cause;
    @(negedge clk); fetch_vld = 1'b0;
    expect_req("R9 next-cycle fetch uses new value", h, c, 1'b1, 3'd1);
  endtask

  task automatic t_map;
    logic h; logic [2:0] c;
    wr(3'd0, 32'h5000_0001);
    wr(3'd4, 32'h0000_0000);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    fire(1'b1, 32'h5000_0000, 1'b0, 0, 1'b0, 4'b0, h, c);
    expect_req("R10 ibp0 kept after writes to 5-7", h, c, 1'b1, 3'd1);
    fire(1'b0, 0, 1'b1, 32'h3000_1000, 1'b1, 4'b0, h, c);
    expect_req("R10 data control kept off", h, c, 1'b0, 3'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_ibp();
    t_ibp_off();
    t_dmodes();
    t_mask();
    t_prio();
    t_pulse();
    t_wr_timing();
    t_map();
    repeat (2) @(posedge clk);
    report();
  end
endmodule